// File: doc/BRIEF.md
# Earliest-Ready Bank Mask Generator

This block looks at every bank of a memory channel that has at least one request waiting and works out which of those banks can be made ready for a column access soonest. A closed bank is ready at the cycle from which it may be activated. An open bank must first be precharged. Its ready time is the precharge-allowed cycle, or the current cycle if that is later, plus the precharge time. The answer is a bit vector with one bit per bank, indexed by global bank number. A request scheduler uses that vector to break ties among requests that do not hit an open row.

Two running-minimum trackers scan the banks in ascending global order. One handles the banks of the rank that carried the last burst. The other handles every other bank. A bank whose ready time is at or below its tracker's running minimum sets its bit. The mask is wiped only when a strictly earlier time appears and the old minimum still lies in the future. As a result, banks that are already ready accumulate rather than displace each other. The same-rank result replaces the general one only when no read/write direction change is pending, at least one same-rank bank qualified, and that rank's earliest bank can be prepared by the earliest-next-command cycle. This avoids a rank-to-rank bus bubble. A start strobe captures the result into a register, and a done pulse follows one cycle later.

Top module: `earliest_bank_mask`

## Requirements
- R1: Only banks whose waiting flag is 1 can have their output bit set; with no waiting bank the output mask is all zeros.
- R2: A closed bank (open flag 0) has ready time equal to its activate-allowed cycle.
- R3: An open bank (open flag 1) has ready time equal to max(precharge-allowed cycle, current cycle) + precharge time, computed one bit wider than the time inputs.
- R4: Within a tracker, banks are visited in ascending global index; a bank whose ready time is less than or equal to the running minimum sets its bit, so equal earliest times all appear in the mask.
- R5: A tracker clears its mask before setting a bit only when the new ready time is strictly below the running minimum and that minimum is later than the current cycle; banks already ready at the current cycle accumulate.
- R6: When the rank count is greater than 1, banks of the active rank feed only the same-rank tracker and all other banks feed the general tracker; when the rank count is 0 or 1, every bank feeds the general tracker.
- R7: The output is the same-rank mask only when the direction-switch flag is 0, at least one same-rank bank qualified, and the same-rank minimum is at or before the earliest-next-command cycle; otherwise it is the general mask.
- R8: Bit b of the output belongs to global bank b = rank * BANKS_PER_RANK + bank-within-rank, and the active-rank input selects banks active_rank*BANKS_PER_RANK up to that plus BANKS_PER_RANK-1.
- R9: The mask and done are registered: done is 1 exactly in the cycle after a cycle with start at 1, and the mask changes only after a start and otherwise holds its value.
- R10: After reset the mask is all zeros and done is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture the computed mask this cycle |
| bank_open | input | NUM_BANKS | 1 when the bank has a row open |
| act_ok_at | input | NUM_BANKS*TIME_W | Per-bank activate-allowed cycle, bank b at bits b*TIME_W |
| pre_ok_at | input | NUM_BANKS*TIME_W | Per-bank precharge-allowed cycle, same packing |
| bank_waiting | input | NUM_BANKS | 1 when a queued request targets the bank |
| now_cyc | input | TIME_W | Current cycle |
| t_precharge | input | TIME_W | Precharge time in cycles |
| active_rank | input | RANK_W | Rank of the previous burst |
| rank_count | input | RCNT_W | Number of ranks populated |
| dir_switch | input | 1 | A read/write direction change is pending |
| next_cmd_at | input | TIME_W | Earliest cycle the next burst can be prepared for |
| ready_mask | output | NUM_BANKS | Registered mask of the earliest-ready banks |
| done | output | 1 | One-cycle pulse after start |

## Verification
The embedded properties check on every cycle that the output never names a bank without a waiting request. They also check that a tracker that qualified any bank produces a non-empty mask, that the active-rank decode selects exactly one rank's worth of banks when ranks are split, that a pending direction switch never lets active-rank bits through, and that done and the held mask follow the start strobe. Whether the right banks win depends on the ready-time arithmetic, the accumulate-versus-clear rule, tie handling and the three-way substitution condition. Only the bench's scenarios can show these, by comparing full masks against hand-worked and independently modelled values.

// File: rtl/bmask_pkg.sv
package bmask_pkg;
  typedef enum logic {
    SRC_GENERAL = 1'b0,
    SRC_SAME    = 1'b1
  } mask_src_e;
endpackage

// File: rtl/bank_ready_calc.sv
module bank_ready_calc #(
  parameter int unsigned NUM_BANKS = 16,
  parameter int unsigned TIME_W    = 16,
  localparam int unsigned RT_W     = TIME_W + 1
) (
  input  logic [NUM_BANKS-1:0]        bank_open,
  input  logic [NUM_BANKS*TIME_W-1:0] act_ok_at,
  input  logic [NUM_BANKS*TIME_W-1:0] pre_ok_at,
  input  logic [TIME_W-1:0]           now_cyc,
  input  logic [TIME_W-1:0]           t_precharge,
  output logic [NUM_BANKS*RT_W-1:0]   ready_at
);
  // ready time of one bank, one bit wider than the time inputs
  function automatic logic [RT_W-1:0] ready_time(
    input logic              is_open,
    input logic [TIME_W-1:0] act_t,
    input logic [TIME_W-1:0] pre_t,
    input logic [TIME_W-1:0] now_t,
    input logic [TIME_W-1:0] tp
  );
    logic [TIME_W-1:0] base;
    base = (pre_t > now_t) ? pre_t : now_t;
    if (is_open) ready_time = {1'b0, base} + {1'b0, tp};
    else         ready_time = {1'b0, act_t};
  endfunction

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign ready_at[b*RT_W +: RT_W] = ready_time(bank_open[b],
                                                 act_ok_at[b*TIME_W +: TIME_W],
                                                 pre_ok_at[b*TIME_W +: TIME_W],
                                                 now_cyc, t_precharge);
  end
endmodule

// File: rtl/rank_region_decode.sv
module rank_region_decode #(
  parameter int unsigned NUM_BANKS      = 16,
  parameter int unsigned BANKS_PER_RANK = 4,
  localparam int unsigned NUM_RANKS     = NUM_BANKS / BANKS_PER_RANK,
  localparam int unsigned RANK_W        = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
  localparam int unsigned RCNT_W        = $clog2(NUM_RANKS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [RANK_W-1:0]    active_rank,
  input  logic [RCNT_W-1:0]    rank_count,
  output logic                 split_en,
  output logic [NUM_BANKS-1:0] in_active_rank
);
  assign split_en = (rank_count > RCNT_W'(1));

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    for (genvar k = 0; k < BANKS_PER_RANK; k++) begin : g_slot
      assign in_active_rank[r*BANKS_PER_RANK + k] =
        split_en && (active_rank == RANK_W'(r));
    end
  end

  // R8
  rank_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (split_en && (32'(active_rank) < NUM_RANKS)) |->
      ($countones(in_active_rank) == BANKS_PER_RANK));
  // R6
  no_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !split_en |-> (in_active_rank == '0));
endmodule

// File: rtl/min_mask_tracker.sv
module min_mask_tracker #(
  parameter int unsigned NUM_BANKS = 16,
  parameter int unsigned TIME_W    = 16,
  localparam int unsigned RT_W     = TIME_W + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_BANKS-1:0]      qualify,
  input  logic [NUM_BANKS*RT_W-1:0] ready_at,
  input  logic [TIME_W-1:0]         now_cyc,
  output logic [NUM_BANKS-1:0]      cand_mask,
  output logic [RT_W-1:0]           min_at,
  output logic                      any_hit
);
  logic [RT_W-1:0]      run_min;
  logic [NUM_BANKS-1:0] run_mask;
  logic                 run_hit;
  logic [RT_W-1:0]      t_b;

  always_comb begin
    run_min  = '1;
    run_mask = '0;
    run_hit  = 1'b0;
    t_b      = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      t_b = ready_at[b*RT_W +: RT_W];
      if (qualify[b] && (t_b <= run_min)) begin
        if ((t_b < run_min) && (run_min > {1'b0, now_cyc})) run_mask = '0;
        run_mask[b] = 1'b1;
        run_min     = t_b;
        run_hit     = 1'b1;
      end
    end
  end

  assign cand_mask = run_mask;
  assign min_at    = run_min;
  assign any_hit   = run_hit;

  // R1
  qual_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_mask & ~qualify) == '0);
  // R4
  hit_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qualify != '0) |-> (cand_mask != '0));
endmodule

// File: rtl/earliest_bank_mask.sv
module earliest_bank_mask
  import bmask_pkg::*;
#(
  parameter int unsigned NUM_BANKS      = 16,
  parameter int unsigned BANKS_PER_RANK = 4,
  parameter int unsigned TIME_W         = 16,
  localparam int unsigned NUM_RANKS     = NUM_BANKS / BANKS_PER_RANK,
  localparam int unsigned RANK_W        = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
  localparam int unsigned RCNT_W        = $clog2(NUM_RANKS + 1),
  localparam int unsigned RT_W          = TIME_W + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [NUM_BANKS-1:0]        bank_open,
  input  logic [NUM_BANKS*TIME_W-1:0] act_ok_at,
  input  logic [NUM_BANKS*TIME_W-1:0] pre_ok_at,
  input  logic [NUM_BANKS-1:0]        bank_waiting,
  input  logic [TIME_W-1:0]           now_cyc,
  input  logic [TIME_W-1:0]           t_precharge,
  input  logic [RANK_W-1:0]           active_rank,
  input  logic [RCNT_W-1:0]           rank_count,
  input  logic                        dir_switch,
  input  logic [TIME_W-1:0]           next_cmd_at,
  output logic [NUM_BANKS-1:0]        ready_mask,
  output logic                        done
);
  logic [NUM_BANKS*RT_W-1:0] ready_at;
  logic                      split_en;
  logic [NUM_BANKS-1:0]      in_rank;
  logic [NUM_BANKS-1:0]      qual_same, qual_gen;
  logic [NUM_BANKS-1:0]      mask_same, mask_gen;
  logic [RT_W-1:0]           min_same, min_gen;
  logic                      hit_same, hit_gen;
  mask_src_e                 src_sel;
  logic [NUM_BANKS-1:0]      mask_next;
  logic [NUM_BANKS-1:0]      mask_q;
  logic                      done_q;

  bank_ready_calc #(.NUM_BANKS(NUM_BANKS), .TIME_W(TIME_W)) u_ready (
    .bank_open(bank_open), .act_ok_at(act_ok_at), .pre_ok_at(pre_ok_at),
    .now_cyc(now_cyc), .t_precharge(t_precharge), .ready_at(ready_at));

  rank_region_decode #(.NUM_BANKS(NUM_BANKS), .BANKS_PER_RANK(BANKS_PER_RANK)) u_rank (
    .clk(clk), .rst_n(rst_n), .active_rank(active_rank), .rank_count(rank_count),
    .split_en(split_en), .in_active_rank(in_rank));

  assign qual_same = bank_waiting & in_rank;
  assign qual_gen  = bank_waiting & ~in_rank;

  min_mask_tracker #(.NUM_BANKS(NUM_BANKS), .TIME_W(TIME_W)) u_same (
    .clk(clk), .rst_n(rst_n), .qualify(qual_same), .ready_at(ready_at),
    .now_cyc(now_cyc), .cand_mask(mask_same), .min_at(min_same), .any_hit(hit_same));

  min_mask_tracker #(.NUM_BANKS(NUM_BANKS), .TIME_W(TIME_W)) u_gen (
    .clk(clk), .rst_n(rst_n), .qualify(qual_gen), .ready_at(ready_at),
    .now_cyc(now_cyc), .cand_mask(mask_gen), .min_at(min_gen), .any_hit(hit_gen));

  always_comb begin
    if (!dir_switch && hit_same && (min_same <= {1'b0, next_cmd_at}))
      src_sel = SRC_SAME;
    else
      src_sel = SRC_GENERAL;
    mask_next = (src_sel == SRC_SAME) ? mask_same : mask_gen;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= start;
      if (start) mask_q <= mask_next;
    end
  end

  assign ready_mask = mask_q;
  assign done       = done_q;

  // R1
  waiting_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ((ready_mask & ~$past(bank_waiting)) == '0));
  // R7
  switch_general_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && dir_switch) |=> ((ready_mask & $past(in_rank)) == '0));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  // R9
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(ready_mask));
endmodule

// File: tb/earliest_bank_mask_bench.sv
module earliest_bank_mask_bench;
  localparam int NB = 16;
  localparam int BPR = 4;
  localparam int TW = 16;

  typedef struct packed {
    logic [15:0] wait_m;
    logic [15:0] open_m;
    logic [15:0] now;
    logic [15:0] tpre;
    logic [15:0] nxt;
    logic [1:0]  arank;
    logic [2:0]  rcnt;
    logic        dsw;
    logic [7:0]  mul;
    logic [7:0]  add;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{16'hFFFF, 16'h0000, 16'd100, 16'd7,  16'd120, 2'd0, 3'd1, 1'b0, 8'd5,  8'd3},
    '{16'hA5A5, 16'h0F0F, 16'd200, 16'd10, 16'd190, 2'd1, 3'd4, 1'b0, 8'd7,  8'd11},
    '{16'h3C3C, 16'hFFFF, 16'd60,  16'd5,  16'd80,  2'd2, 3'd4, 1'b1, 8'd9,  8'd2},
    '{16'h00FF, 16'h5555, 16'd300, 16'd12, 16'd330, 2'd3, 3'd4, 1'b0, 8'd13, 8'd17},
    '{16'h1234, 16'h0000, 16'd50,  16'd3,  16'd40,  2'd0, 3'd2, 1'b0, 8'd3,  8'd29},
    '{16'hFFFF, 16'hAAAA, 16'd150, 16'd20, 16'd200, 2'd1, 3'd4, 1'b0, 8'd11, 8'd5},
    '{16'h8001, 16'h8000, 16'd90,  16'd8,  16'd95,  2'd3, 3'd4, 1'b0, 8'd1,  8'd1},
    '{16'h0000, 16'hFFFF, 16'd120, 16'd4,  16'd130, 2'd0, 3'd4, 1'b0, 8'd2,  8'd2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [NB-1:0] bank_open = '0;
  logic [NB-1:0] bank_waiting = '0;
  logic [TW-1:0] act_a [NB];
  logic [TW-1:0] pre_a [NB];
  logic [NB*TW-1:0] act_flat, pre_flat;
  logic [TW-1:0] now_cyc = '0, t_pre = '0, next_cmd = '0;
  logic [1:0] arank = '0;
  logic [2:0] rcnt = '0;
  logic dsw = 1'b0;
  logic [NB-1:0] ready_mask;
  logic done;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  always_comb
    for (int b = 0; b < NB; b++) begin
      act_flat[b*TW +: TW] = act_a[b];
      pre_flat[b*TW +: TW] = pre_a[b];
    end

  earliest_bank_mask u_earliest_bank_mask (
    .clk(clk), .rst_n(rst_n), .start(start), .bank_open(bank_open),
    .act_ok_at(act_flat), .pre_ok_at(pre_flat), .bank_waiting(bank_waiting),
    .now_cyc(now_cyc), .t_precharge(t_pre), .active_rank(arank),
    .rank_count(rcnt), .dir_switch(dsw), .next_cmd_at(next_cmd),
    .ready_mask(ready_mask), .done(done));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_all();
    bank_open = '0; bank_waiting = '0;
    for (int b = 0; b < NB; b++) begin act_a[b] = 16'hF000; pre_a[b] = '0; end
    now_cyc = 16'd100; t_pre = 16'd7; next_cmd = '0;
    arank = '0; rcnt = 3'd1; dsw = 1'b0;
  endtask

  // called at a falling edge; returns at the falling edge after capture
  task automatic fire();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // independent model: ready time per bank, then a scan per group
  function automatic logic [NB-1:0] model();
    logic [16:0] rt [NB];
    logic [NB-1:0] res [2];
    logic [16:0] best [2];
    logic found [2];
    logic [1:0] grp;
    for (int b = 0; b < NB; b++) begin
      if (bank_open[b])
        rt[b] = 17'(((pre_a[b] > now_cyc) ? pre_a[b] : now_cyc)) + 17'(t_pre);
      else
        rt[b] = 17'(act_a[b]);
    end
    for (int g = 0; g < 2; g++) begin res[g] = '0; best[g] = 17'h1FFFF; found[g] = 1'b0; end
    for (int b = 0; b < NB; b++) begin
      if (!bank_waiting[b]) continue;
      grp = ((rcnt > 3'd1) && ((b / BPR) == int'(arank))) ? 2'd1 : 2'd0;
      if (rt[b] > best[grp]) continue;
      if (rt[b] != best[grp] && best[grp] > 17'(now_cyc)) res[grp] = '0;
      res[grp][b] = 1'b1;
      best[grp] = rt[b];
      found[grp] = 1'b1;
    end
    if (found[1] && !dsw && best[1] <= 17'(next_cmd)) return res[1];
    return res[0];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [NB-1:0] prev;
    clear_all();
    repeat (3) @(negedge clk);
    check("R10 reset mask", 32'(ready_mask), 32'h0);
    check("R10 reset done", 32'(done), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk against the independent model
    for (int v = 0; v < 8; v++) begin
      bank_waiting = VECS[v].wait_m; bank_open = VECS[v].open_m;
      now_cyc = VECS[v].now; t_pre = VECS[v].tpre; next_cmd = VECS[v].nxt;
      arank = VECS[v].arank; rcnt = VECS[v].rcnt; dsw = VECS[v].dsw;
      for (int b = 0; b < NB; b++) begin
        act_a[b] = VECS[v].now - 16'd40 + 16'((b * int'(VECS[v].mul) + int'(VECS[v].add)) % 64);
        pre_a[b] = VECS[v].now - 16'd30 + 16'((b * int'(VECS[v].add) + int'(VECS[v].mul)) % 64);
      end
      fire();
      check($sformatf("R4 R5 R6 R7 table vector %0d", v), 32'(ready_mask), 32'(model()));
      check("R9 done pulse", 32'(done), 32'h1);
      @(negedge clk);
      check("R9 done falls", 32'(done), 32'h0);
    end

    // R1: nothing waiting gives an empty mask
    clear_all(); act_a[2] = 16'd10; fire();
    check("R1 no waiting", 32'(ready_mask), 32'h0);

    // R5 accumulate: all ready at now=100
    clear_all(); bank_waiting = 16'h0224;
    act_a[2] = 16'd90; act_a[5] = 16'd80; act_a[9] = 16'd50; fire();
    check("R5 ready banks accumulate", 32'(ready_mask), 32'h0224);

    // R5 clear in future, R4 tie
    now_cyc = 16'd10; bank_waiting = 16'h1224; act_a[12] = 16'd50; fire();
    check("R4 R5 future minimum clears, tie kept", 32'(ready_mask), 32'h1200);

    // R2/R3 open vs closed
    clear_all(); bank_waiting = 16'h0048; act_a[3] = 16'd120;
    bank_open[6] = 1'b1; pre_a[6] = 16'd112; fire();
    check("R3 open ready 119 beats closed 120", 32'(ready_mask), 32'h0040);
    pre_a[6] = 16'd114; fire();
    check("R2 closed ready 120 beats open 121", 32'(ready_mask), 32'h0008);
    pre_a[6] = 16'd40; act_a[3] = 16'd50; fire();
    check("R3 open uses current cycle when later", 32'(ready_mask), 32'h0008);

    // R6/R7/R8 rank split
    clear_all(); rcnt = 3'd4; arank = 2'd1; next_cmd = 16'd110;
    bank_waiting = 16'h0021; act_a[0] = 16'd50; act_a[5] = 16'd105; fire();
    check("R7 R8 same rank bank 5 chosen", 32'(ready_mask), 32'h0020);
    dsw = 1'b1; fire();
    check("R7 switch pending uses general", 32'(ready_mask), 32'h0001);
    dsw = 1'b0; next_cmd = 16'd104; fire();
    check("R7 same rank too late uses general", 32'(ready_mask), 32'h0001);
    act_a[5] = 16'd40; rcnt = 3'd1; fire();
    check("R6 single rank merges all banks", 32'(ready_mask), 32'h0021);
    rcnt = 3'd4; next_cmd = 16'd110; fire();
    check("R6 split keeps same rank apart", 32'(ready_mask), 32'h0020);

    // R9 hold without start
    prev = ready_mask;
    bank_waiting = 16'hFFFF; act_a[5] = 16'd999;
    @(negedge clk); @(negedge clk);
    check("R9 mask holds without start", 32'(ready_mask), 32'(prev));
    check("R9 no done without start", 32'(done), 32'h0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule